// File: doc/BRIEF.md
# Cascadable Codec Serial Port Slice

This block is one channel of a daisy-chained codec serial interface. Channels are chained output to input, and a host serial port sits at both ends of the chain. Each channel receives 16-bit words on a serial input marked by a one-cycle frame pulse. It emits words on a serial output with its own frame pulse, which feeds the next channel. When a sample event occurs, the channel starts a frame that carries its local converter word.

Routing has two modes. In program mode, a word with the control flag set carries a channel address. A channel that sees address zero keeps the word: it writes one of three 8-bit configuration registers, or it answers a read. A channel that sees a nonzero address subtracts one from the address and passes the word on. In data mode the channel counts the words it receives. When the count reaches the channel total programmed in register A, the channel keeps that word as its DAC word. Words that arrive before the count is reached are passed on. Because every channel makes its decision a fixed time after a word ends, channels that receive their words together also update together.

Top module: `csp_slice`

## Requirements
- R1: A frame is a one-cycle pulse on the frame input or output, followed in the next 16 cycles by 16 bits, most significant bit first. The output frame pulse is never longer than one cycle.
- R2: When the sample strobe is high in a cycle, the frame output pulses in the next cycle and the local ADC word is shifted out after it. At each sample interval the host receives the last channel's own ADC word first.
- R3: In program mode, a word with bit 15 = 1 (control), bit 14 = 0 (write), bits 13:11 = 0 (address) and bits 10:8 = 0, 1 or 2 writes bits 7:0 into register A, B or C. The word is not forwarded.
- R4: In program mode, a control word with bits 13:11 nonzero is forwarded with that field reduced by one. All of its other bits stay unchanged.
- R5: In program mode, a word with bit 15 = 0 is forwarded unchanged.
- R6: In program mode, a control word with address zero, bit 14 = 1 and a select of 0 to 2 is forwarded as a reply. The reply has bit 15 cleared, bits 14:8 kept, and bits 7:0 replaced by the contents of the selected register.
- R7: In program mode, a control word with address zero and a select of 3 to 7 is absorbed. No register changes and nothing is forwarded.
- R8: After reset, all registers and the DAC word are zero and no frame or load pulse is active. In register A, bit 0 = 1 selects data mode and bits 7:5 hold the channel count.
- R9: In data mode, a received word that brings the word count up to the channel count is loaded into the DAC output. A one-cycle load pulse marks the load, and the count restarts from zero. The count starts from zero when register A is written.
- R10: In data mode, a received word that does not reach the count is forwarded unchanged, even when bit 15 is set.
- R11: In data mode, registers A, B and C do not change.
- R12: A channel count of zero behaves as a count of one.
- R13: A forwarded word's frame pulse, a register write and a DAC load all become visible in the second cycle after the word's last bit. Two chained channels that receive paired words at the same time therefore update on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdi | input | 1 | Serial data in |
| sdifs | input | 1 | Input frame pulse |
| sample_evt | input | 1 | Sample event strobe |
| adc_word | input | 16 | Local ADC word sent at a sample event |
| sdo | output | 1 | Serial data out |
| sdofs | output | 1 | Output frame pulse |
| reg_a | output | 8 | Register A (mode bit and channel count) |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |
| dac_word | output | 16 | Latched DAC word |
| dac_load | output | 1 | One-cycle pulse when the DAC word loads |

## Verification
The assertions check these properties on every cycle:
- the output frame pulse is one cycle wide and follows each sample strobe;
- the DAC word changes only with a load pulse, and loads only occur in data mode;
- registers stay frozen once data mode is set.

Other behaviour depends on whole frames and on word order, so only the bench scenarios can show it. This covers address decrementing across two channels, read replies, absorbed selects, the count-reached latch, and the rule that a zero count means one. It also covers cycle-exact agreement of register writes and DAC loads between the two chained channels.

// File: rtl/csp_pkg.sv
package csp_pkg;
   // Routing outcome for a completed received word
   typedef enum logic [1:0] {
      RT_DROP  = 2'd0,
      RT_FWD   = 2'd1,
      RT_STORE = 2'd2,
      RT_DAC   = 2'd3
   } route_e;

   localparam int NUM_CFG_REGS = 3;
endpackage

// File: rtl/csp_rx.sv
module csp_rx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ser_in,
   input  logic         frm_in,
   output logic [W-1:0] word,
   output logic         done
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] left_q;

   if (W < 2) begin : g_bad_w
      $error("csp_rx: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
         word   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (frm_in) begin
            left_q <= CW'(W);
         end else if (left_q != '0) begin
            sh_q   <= {sh_q[W-2:0], ser_in};
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
               word <= {sh_q[W-2:0], ser_in};
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   output logic         ser_out,
   output logic         frm_out
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         ser_out <= 1'b0;
         frm_out <= 1'b0;
      end else begin
         frm_out <= load;
         if (load) begin
            sh_q    <= load_word;
            left_q  <= CW'(W);
            ser_out <= 1'b0;
         end else if (left_q != '0) begin
            ser_out <= sh_q[W-1];
            sh_q    <= sh_q << 1;
            left_q  <= left_q - 1'b1;
         end else begin
            ser_out <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
   import csp_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int SEL_W       = 3,
   parameter int DATA_W      = 8,
   parameter bit ZERO_AS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [WORD_W-1:0] rx_word,
   output logic              fwd_vld,
   output logic [WORD_W-1:0] fwd_word,
   output logic [DATA_W-1:0] cfg_a,
   output logic [DATA_W-1:0] cfg_b,
   output logic [DATA_W-1:0] cfg_c,
   output logic [WORD_W-1:0] dac_q,
   output logic              dac_pulse
);
   localparam int CTL_BIT  = WORD_W - 1;
   localparam int RD_BIT   = WORD_W - 2;
   localparam int ADDR_LSB = SEL_W + DATA_W;
   localparam int SEL_LSB  = DATA_W;
   localparam int CNT_LSB  = DATA_W - ADDR_W;
   localparam int NREG     = NUM_CFG_REGS;

   if (WORD_W != 2 + ADDR_W + SEL_W + DATA_W) begin : g_bad_layout
      $error("csp_ctrl: word width does not match field widths");
   end
   if (CNT_LSB < 1) begin : g_bad_cnt
      $error("csp_ctrl: count field overlaps mode bit");
   end
   if ((1 << SEL_W) < NREG) begin : g_bad_sel
      $error("csp_ctrl: select field too narrow");
   end

   logic [DATA_W-1:0] regs_q [NREG];
   logic [ADDR_W-1:0] frm_cnt_q;
   logic [ADDR_W-1:0] dev_cnt;
   logic [ADDR_W:0]   eff_cnt;
   logic              data_mode;
   logic [ADDR_W-1:0] w_addr;
   logic [SEL_W-1:0]  w_sel;
   logic [DATA_W-1:0] rd_val;
   logic              cnt_hit;
   route_e            route;

   assign data_mode = regs_q[0][0];
   assign dev_cnt   = regs_q[0][CNT_LSB +: ADDR_W];
   assign w_addr    = rx_word[ADDR_LSB +: ADDR_W];
   assign w_sel     = rx_word[SEL_LSB +: SEL_W];

   // Meaning of a zero channel count is a build option
   if (ZERO_AS_ONE) begin : g_zero_one
      assign eff_cnt = (dev_cnt == '0) ? (ADDR_W+1)'(1) : {1'b0, dev_cnt};
   end else begin : g_zero_full
      assign eff_cnt = (dev_cnt == '0) ? {1'b1, {ADDR_W{1'b0}}} : {1'b0, dev_cnt};
   end

   assign cnt_hit = (({1'b0, frm_cnt_q} + 1'b1) == eff_cnt);

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NREG; i++) begin
         if (w_sel == SEL_W'(i)) rd_val = regs_q[i];
      end
   end

   always_comb begin
      route    = RT_DROP;
      fwd_word = rx_word;
      if (data_mode) begin
         route = cnt_hit ? RT_DAC : RT_FWD;
      end else if (!rx_word[CTL_BIT]) begin
         route = RT_FWD;
      end else if (w_addr != '0) begin
         route = RT_FWD;
         fwd_word[ADDR_LSB +: ADDR_W] = w_addr - 1'b1;
      end else if (w_sel > SEL_W'(NREG - 1)) begin
         route = RT_DROP;
      end else if (rx_word[RD_BIT]) begin
         route = RT_FWD;
         fwd_word[CTL_BIT]      = 1'b0;
         fwd_word[DATA_W-1:0]   = rd_val;
      end else begin
         route = RT_STORE;
      end
   end

   assign fwd_vld = rx_done && (route == RT_FWD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
         frm_cnt_q <= '0;
         dac_q     <= '0;
         dac_pulse <= 1'b0;
      end else begin
         dac_pulse <= 1'b0;
         if (rx_done) begin
            unique case (route)
               RT_STORE: begin
                  for (int i = 0; i < NREG; i++) begin
                     if (w_sel == SEL_W'(i)) regs_q[i] <= rx_word[DATA_W-1:0];
                  end
                  if (w_sel == '0) frm_cnt_q <= '0;
               end
               RT_DAC: begin
                  dac_q     <= rx_word;
                  dac_pulse <= 1'b1;
                  frm_cnt_q <= '0;
               end
               RT_FWD: begin
                  if (data_mode) frm_cnt_q <= frm_cnt_q + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign cfg_a = regs_q[0];
   assign cfg_b = regs_q[1];
   assign cfg_c = regs_q[2];
endmodule

// File: rtl/csp_slice.sv
module csp_slice #(
   parameter int  ADDR_W      = 3,
   parameter int  SEL_W       = 3,
   parameter int  DATA_W      = 8,
   parameter bit  ZERO_AS_ONE = 1'b1,
   localparam int WORD_W      = 2 + ADDR_W + SEL_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdi,
   input  logic              sdifs,
   input  logic              sample_evt,
   input  logic [WORD_W-1:0] adc_word,
   output logic              sdo,
   output logic              sdofs,
   output logic [DATA_W-1:0] reg_a,
   output logic [DATA_W-1:0] reg_b,
   output logic [DATA_W-1:0] reg_c,
   output logic [WORD_W-1:0] dac_word,
   output logic              dac_load
);
   logic [WORD_W-1:0] rx_word;
   logic              rx_done;
   logic              fwd_vld;
   logic [WORD_W-1:0] fwd_word;
   logic              tx_load;
   logic [WORD_W-1:0] tx_word;

   csp_rx #(.W(WORD_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ser_in (sdi),
      .frm_in (sdifs),
      .word   (rx_word),
      .done   (rx_done)
   );

   csp_ctrl #(
      .WORD_W      (WORD_W),
      .ADDR_W      (ADDR_W),
      .SEL_W       (SEL_W),
      .DATA_W      (DATA_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_done   (rx_done),
      .rx_word   (rx_word),
      .fwd_vld   (fwd_vld),
      .fwd_word  (fwd_word),
      .cfg_a     (reg_a),
      .cfg_b     (reg_b),
      .cfg_c     (reg_c),
      .dac_q     (dac_word),
      .dac_pulse (dac_load)
   );

   // Local sample takes the transmitter ahead of a forwarded word
   assign tx_load = sample_evt | fwd_vld;
   assign tx_word = sample_evt ? adc_word : fwd_word;

   csp_tx #(.W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_word (tx_word),
      .ser_out   (sdo),
      .frm_out   (sdofs)
   );
endmodule

// File: rtl/csp_slice_chk.sv
module csp_slice_chk #(
   parameter int DATA_W = 8,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_evt,
   input logic              sdofs,
   input logic              dac_load,
   input logic [WORD_W-1:0] dac_word,
   input logic [DATA_W-1:0] reg_a,
   input logic [DATA_W-1:0] reg_b,
   input logic [DATA_W-1:0] reg_c
);
   p_fs_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sdofs |=> !sdofs);

   p_evt_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_evt |=> sdofs);

   p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_load |-> $stable(dac_word));

   p_load_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |-> reg_a[0]);

   p_load_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |=> !dac_load);

   p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_a[0] |=> ($stable(reg_a) && $stable(reg_b) && $stable(reg_c)));
endmodule

bind csp_slice csp_slice_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_evt (sample_evt),
   .sdofs      (sdofs),
   .dac_load   (dac_load),
   .dac_word   (dac_word),
   .reg_a      (reg_a),
   .reg_b      (reg_b),
   .reg_c      (reg_c)
);

// File: tb/csp_slice_test.sv
`timescale 1ns/1ps
module csp_slice_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_sdi = 1'b0;
   logic host_fs = 1'b0;
   logic evt = 1'b0;
   logic [15:0] adc1 = '0;
   logic [15:0] adc2 = '0;

   logic        s1_sdo, s1_fs, s2_sdo, s2_fs, dl1, dl2;
   logic [7:0]  ra1, rb1, rc1, ra2, rb2, rc2;
   logic [15:0] dw1, dw2;

   int tests = 0;
   int fails = 0;
   bit ended = 1'b0;

   always #4 clk = ~clk;

   // First channel: fed by the host
   csp_slice uut (
      .clk(clk), .rst_n(rst_n), .sdi(host_sdi), .sdifs(host_fs),
      .sample_evt(evt), .adc_word(adc1), .sdo(s1_sdo), .sdofs(s1_fs),
      .reg_a(ra1), .reg_b(rb1), .reg_c(rc1), .dac_word(dw1), .dac_load(dl1)
   );

   // Second channel: returns to the host
   csp_slice uut_nxt (
      .clk(clk), .rst_n(rst_n), .sdi(s1_sdo), .sdifs(s1_fs),
      .sample_evt(evt), .adc_word(adc2), .sdo(s2_sdo), .sdofs(s2_fs),
      .reg_a(ra2), .reg_b(rb2), .reg_c(rc2), .dac_word(dw2), .dac_load(dl2)
   );

   // Behavioural channel model
   logic [7:0]  m_reg [2][3];
   logic [15:0] m_dac [2];
   int          m_cnt [2];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic mdl_reset();
      for (int c = 0; c < 2; c++) begin
         for (int r = 0; r < 3; r++) m_reg[c][r] = 8'h00;
         m_dac[c] = 16'h0000;
         m_cnt[c] = 0;
      end
   endtask

   function automatic void mdl(input int ch, input logic [15:0] w,
                               output bit fwd, output logic [15:0] o);
      int eff;
      int sel;
      o   = w;
      fwd = 1'b0;
      sel = int'(w[10:8]);
      if (m_reg[ch][0][0]) begin
         eff = (m_reg[ch][0][7:5] == 3'd0) ? 1 : int'(m_reg[ch][0][7:5]);
         m_cnt[ch]++;
         if (m_cnt[ch] == eff) begin
            m_dac[ch] = w;
            m_cnt[ch] = 0;
         end else begin
            fwd = 1'b1;
         end
      end else if (!w[15]) begin
         fwd = 1'b1;
      end else if (w[13:11] != 3'd0) begin
         fwd = 1'b1;
         o[13:11] = w[13:11] - 3'd1;
      end else if (sel > 2) begin
         fwd = 1'b0;
      end else if (w[14]) begin
         fwd = 1'b1;
         o[15] = 1'b0;
         o[7:0] = m_reg[ch][sel];
      end else begin
         m_reg[ch][sel] = w[7:0];
         if (sel == 0) m_cnt[ch] = 0;
      end
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      evt = 1'b0; host_fs = 1'b0; host_sdi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mdl_reset();
      @(negedge clk);
   endtask

   // One sample interval: host sends w1 (paired with next channel) then w2
   task automatic run_frame(input logic [15:0] w1, input logic [15:0] w2,
                            input logic [15:0] a1, input logic [15:0] a2,
                            input bit sync_reg, input bit sync_dac, input string tag);
      logic [15:0] q1[$];
      logic [15:0] expq[$];
      logic [15:0] got[$];
      logic [15:0] o;
      logic [15:0] cap;
      logic [23:0] snap1, snap2;
      bit f;
      int cap_left;
      int chg1, chg2;
      q1.delete(); expq.delete(); got.delete();
      q1.push_back(a1);
      mdl(0, w1, f, o); if (f) q1.push_back(o);
      mdl(0, w2, f, o); if (f) q1.push_back(o);
      expq.push_back(a2);
      foreach (q1[i]) begin
         mdl(1, q1[i], f, o);
         if (f) expq.push_back(o);
      end
      adc1 = a1; adc2 = a2;
      cap = '0; cap_left = 0; chg1 = -1; chg2 = -1;
      snap1 = '0; snap2 = '0;
      for (int c = 0; c < 76; c++) begin
         @(negedge clk);
         if (c == 0) begin
            snap1 = {ra1, rb1, rc1};
            snap2 = {ra2, rb2, rc2};
         end
         if (cap_left > 0) begin
            cap = {cap[14:0], s2_sdo};
            cap_left--;
            if (cap_left == 0) got.push_back(cap);
         end
         if (s2_fs) cap_left = 16;
         if (chg1 < 0 && {ra1, rb1, rc1} != snap1) chg1 = c;
         if (chg2 < 0 && {ra2, rb2, rc2} != snap2) chg2 = c;
         if (sync_dac) begin
            check(dl1 == dl2, "R13", "dac_load ch1 vs ch2", longint'(dl1), longint'(dl2));
            if (c == 37) check(dl1 == 1'b1, "R9", "dac_load at cycle 37", longint'(dl1), 1);
         end
         evt      = (c == 0);
         host_fs  = (c == 1) || (c == 19);
         if (c >= 2 && c <= 17)       host_sdi = w1[17-c];
         else if (c >= 20 && c <= 35) host_sdi = w2[35-c];
         else                         host_sdi = 1'b0;
      end
      check(got.size() == expq.size(), tag, "returned word count",
            longint'(got.size()), longint'(expq.size()));
      if (got.size() > 0)
         check(got[0] == a2, "R2", "first returned word", longint'(got[0]), longint'(a2));
      for (int i = 0; i < got.size() && i < expq.size(); i++)
         check(got[i] == expq[i], tag, "R1 returned word", longint'(got[i]), longint'(expq[i]));
      check(ra1 == m_reg[0][0], tag, "ch1 reg_a", longint'(ra1), longint'(m_reg[0][0]));
      check(rb1 == m_reg[0][1], tag, "ch1 reg_b", longint'(rb1), longint'(m_reg[0][1]));
      check(rc1 == m_reg[0][2], tag, "ch1 reg_c", longint'(rc1), longint'(m_reg[0][2]));
      check(ra2 == m_reg[1][0], tag, "ch2 reg_a", longint'(ra2), longint'(m_reg[1][0]));
      check(rb2 == m_reg[1][1], tag, "ch2 reg_b", longint'(rb2), longint'(m_reg[1][1]));
      check(rc2 == m_reg[1][2], tag, "ch2 reg_c", longint'(rc2), longint'(m_reg[1][2]));
      check(dw1 == m_dac[0], tag, "ch1 dac_word", longint'(dw1), longint'(m_dac[0]));
      check(dw2 == m_dac[1], tag, "ch2 dac_word", longint'(dw2), longint'(m_dac[1]));
      if (sync_reg) begin
         check(chg1 == 37, "R13", "ch1 register update cycle", longint'(chg1), 37);
         check(chg2 == 37, "R13", "ch2 register update cycle", longint'(chg2), 37);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      do_reset();
      // R8: reset state
      check({ra1, rb1, rc1, ra2, rb2, rc2} == 48'h0, "R8", "registers after reset",
            longint'({ra1, rb1, rc1, ra2, rb2, rc2}), 0);
      check(dw1 == 16'h0 && dw2 == 16'h0, "R8", "dac after reset", longint'({dw1, dw2}), 0);
      check(!s1_fs && !s2_fs && !dl1 && !dl2, "R8", "pulses after reset",
            longint'({s1_fs, s2_fs, dl1, dl2}), 0);

      run_frame(16'h895A, 16'h815A, 16'h1234, 16'h0ABC, 1'b1, 1'b0, "R3");
      run_frame(16'h8A33, 16'h8244, 16'h2345, 16'h3456, 1'b1, 1'b0, "R3");
      run_frame(16'hC900, 16'hC200, 16'h0111, 16'h0222, 1'b0, 1'b0, "R6");
      run_frame(16'h7FFF, 16'h90FF, 16'h9800, 16'h0001, 1'b0, 1'b0, "R4/R5");
      run_frame(16'h8D11, 16'h8722, 16'h0333, 16'h0444, 1'b0, 1'b0, "R7");
      // Enter data mode, channel count 2 (A = 0x41)
      run_frame(16'h8841, 16'h8041, 16'h0555, 16'h0666, 1'b1, 1'b0, "R8");
      check(ra1 == 8'h41 && ra2 == 8'h41, "R8", "mode and count in reg A",
            longint'({ra1, ra2}), longint'(16'h4141));
      run_frame(16'hBEEF, 16'hC0DE, 16'h1111, 16'h2222, 1'b0, 1'b1, "R9");
      run_frame(16'h8800, 16'h0F0F, 16'h3333, 16'h4444, 1'b0, 1'b1, "R10");
      check(dw2 == 16'h8800, "R10", "control-looking DAC word kept whole",
            longint'(dw2), longint'(16'h8800));
      check(ra1 == 8'h41 && rb1 == 8'h5A && rc1 == 8'h44, "R11", "ch1 regs frozen",
            longint'({ra1, rb1, rc1}), longint'(24'h415A44));
      check(ra2 == 8'h41 && rb2 == 8'h5A && rc2 == 8'h33, "R11", "ch2 regs frozen",
            longint'({ra2, rb2, rc2}), longint'(24'h415A33));

      do_reset();
      run_frame(16'h8801, 16'h8001, 16'h0010, 16'h0020, 1'b1, 1'b0, "R12");
      run_frame(16'h5555, 16'h6666, 16'h7777, 16'h0123, 1'b0, 1'b0, "R12");
      check(dw1 == 16'h6666 && dw2 == 16'h7777, "R12", "count zero latches every word",
            longint'({dw1, dw2}), longint'(32'h66667777));

      finish_run();
   end
endmodule